// File: doc/BRIEF.md
# Line-Doubled Monochrome Scanout Serializer

This block turns a one-bit-per-pixel framebuffer into a serial pixel stream for the visible part of each display line. A line-start pulse arrives at the end of horizontal blanking together with the current line number. If that line lies inside the vertical active window, the block reads the current framebuffer row through a synchronous read port. The port takes an address and returns data one cycle later, and each row is a run of 16-bit words. The block then shifts the row out one pixel per clock, least significant bit first.

Vertical line doubling comes from the row pointer. The pointer moves forward by one framebuffer stride only after a line whose distance from the first active line is odd, so every source row appears on two display lines in a row. Any line-start pulse on a line outside the window sends the pointer back to the framebuffer base. The single pixel bit drives the red, green and blue outputs together.

The row length in pixels, the stride, the base address and the window position are parameters. Sync timing and the memory itself belong to the surrounding logic.

Top module: `mono_scanout`

## Requirements
- R1: While reset is held, and after it is released, `pix_o`, `rgb_o` and `rd_en_o` are low and the row pointer sits at `FB_BASE`.
- R2: All three bits of `rgb_o` equal `pix_o` in every cycle.
- R3: A line-start pulse on a line in the window [`VFIRST`, `VFIRST+VLINES`) asserts `rd_en_o` in the next cycle with `rd_addr_o` equal to the row pointer.
- R4: Bit i of the row's word k appears on `pix_o` in cycle 3+16k+i, where cycle 0 is the cycle in which the line-start pulse is high. Bit 0 of each word goes out first.
- R5: After an active line, the row pointer grows by `STRIDE` only if (line − `VFIRST`) is odd. Otherwise it stays the same, so each row is shown on two lines.
- R6: A line-start pulse on a line outside the window sets the row pointer to `FB_BASE`. The next active line, even an odd-offset one, therefore reads row 0.
- R7: Each active line reads exactly (`ROW_PIXELS`/8 + 2)/2 words at consecutive addresses. `pix_o` is low from the cycle after the last word's bit 15 onward.
- R8: Words follow each other on `pix_o` with no idle cycle between bit 15 of one word and bit 0 of the next.
- R9: A line-start pulse outside the window issues no read and leaves `pix_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle pulse at the end of horizontal blanking |
| line_num_i | input | LINE_W | Display line number, valid with the pulse |
| rd_en_o | output | 1 | Framebuffer read request |
| rd_addr_o | output | ADDR_W | Framebuffer word address |
| rd_data_i | input | 16 | Read data, valid in the cycle after the request |
| pix_o | output | 1 | Serial pixel bit |
| rgb_o | output | 3 | Red, green and blue, each equal to the pixel bit |

## Verification
The read request is due one cycle after the line-start cycle. The first pixel is due three cycles after it, because the start register, the memory read and the shift-register load each add one cycle. Each later bit follows one cycle after the one before it. The bench drives the pulse between falling edges, counts falling edges from that point, and compares each sample with a model built from the stored pattern at exactly index 3+16k+i. Row selection is checked through the first address of each line against a pointer computed from the line sequence. This covers sequences that re-enter the window partway down and a reset in the middle of a line.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int WORD_W = 16;

  // one spare word beyond the visible pixels
  function automatic int words_per_row(input int pixels);
    return ((pixels / 8) + 2) / 2;
  endfunction
endpackage

// File: rtl/row_tracker.sv
module row_tracker #(
  parameter int LINE_W  = 10,
  parameter int ADDR_W  = 8,
  parameter int VFIRST  = 2,
  parameter int VLINES  = 6,
  parameter int STRIDE  = 6,
  parameter int FB_BASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_num_i,
  output logic              in_win_o,
  output logic [ADDR_W-1:0] row_o
);
  localparam logic VPAR = 1'(VFIRST % 2);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] row_q;
  logic              odd_off;

  assign in_win_o = (int'(line_num_i) >= VFIRST) && (int'(line_num_i) < VFIRST + VLINES);
  assign odd_off  = line_num_i[0] ^ VPAR;
  assign row_o    = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= BASE_A;
    else if (line_start_i) begin
      if (!in_win_o)    row_q <= BASE_A;
      else if (odd_off) row_q <= row_q + STEP_A;
    end
  end

  a_r5_even_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && in_win_o && !odd_off) |=> $stable(row_q));
  a_r5_odd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && in_win_o && odd_off) |=> (row_q == $past(row_q) + STEP_A));
  a_r6_blank_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !in_win_o) |=> (row_q == BASE_A));
endmodule

// File: rtl/word_fetch.sv
module word_fetch #(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              need_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              load_o
);
  localparam int CNT_W = $clog2(NWORDS + 1);

  logic              first_q, pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  assign req_o  = (first_q || need_i) && (left_q != '0);
  assign addr_o = addr_q;
  assign load_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      first_q <= 1'b1;
      pend_q  <= 1'b0;
      addr_q  <= start_addr_i;
      left_q  <= CNT_W'(NWORDS);
    end else begin
      first_q <= 1'b0;
      pend_q  <= req_o;
      if (req_o) begin
        addr_q <= addr_q + ADDR_W'(1);
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  a_r3_fetch_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> req_o);
  a_r7_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !start_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/pix_shift.sv
module pix_shift
  import scan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              need_o,
  output logic              pix_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  cnt_q;
  logic              run_q;

  // request next word one bit early so its data lands on the last bit
  assign need_o = run_q && (cnt_q == LAST - BIT_W'(1));
  assign pix_o  = run_q && sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + BIT_W'(1);
      if (cnt_q == LAST) run_q <= 1'b0;
    end
  end

  a_r8_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == LAST && load_i && !start_i) |=> run_q);
endmodule

// File: rtl/mono_scanout.sv
module mono_scanout
  import scan_pkg::*;
#(
  parameter int LINE_W     = 10,
  parameter int ADDR_W     = 8,
  parameter int ROW_PIXELS = 64,
  parameter int STRIDE     = 6,
  parameter int FB_BASE    = 4,
  parameter int VFIRST     = 2,
  parameter int VLINES     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_num_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [15:0]       rd_data_i,
  output logic              pix_o,
  output logic [2:0]        rgb_o
);
  localparam int NWORDS = words_per_row(ROW_PIXELS);

  logic              in_win, start, need, load, pix;
  logic [ADDR_W-1:0] row;

  assign start = line_start_i && in_win;

  row_tracker #(
    .LINE_W(LINE_W), .ADDR_W(ADDR_W), .VFIRST(VFIRST), .VLINES(VLINES),
    .STRIDE(STRIDE), .FB_BASE(FB_BASE)
  ) u_row (
    .clk_i, .rst_ni, .line_start_i, .line_num_i,
    .in_win_o(in_win), .row_o(row)
  );

  word_fetch #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_fetch (
    .clk_i, .rst_ni, .start_i(start), .start_addr_i(row), .need_i(need),
    .req_o(rd_en_o), .addr_o(rd_addr_o), .load_o(load)
  );

  pix_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .load_i(load), .data_i(rd_data_i),
    .need_o(need), .pix_o(pix)
  );

  assign pix_o = pix;
  assign rgb_o = {3{pix}};

  a_r9_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_start_i && !in_win && !rd_en_o && !load) |=> !load);
endmodule

// File: tb/mono_scanout_test.sv
module mono_scanout_test;
  localparam int CLK_P   = 10;
  localparam int BASE    = 4;
  localparam int STRIDE  = 6;
  localparam int NWORDS  = 5;
  localparam int NPIX    = NWORDS * 16;
  // {line[15:8], active[7], row[6:0]}
  localparam logic [15:0] VEC [14] = '{
    16'h0000, 16'h0100, 16'h0280, 16'h0380, 16'h0481, 16'h0581, 16'h0682,
    16'h0782, 16'h0800, 16'h0280, 16'h0380, 16'h0481, 16'h0900, 16'h0580};

  logic        clk = 0, rst_n = 0, ls = 0;
  logic [9:0]  ln = '0;
  logic        rd_en, pix;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data = '0;
  logic [2:0]  rgb;
  logic [15:0] mem [256];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  mono_scanout uut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(ls), .line_num_i(ln),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .pix_o(pix), .rgb_o(rgb));

  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int row, input int n);
    if (n < 0 || n >= NPIX) return 1'b0;
    return mem[BASE + row*STRIDE + n/16][n%16];
  endfunction

  task automatic run_line(input int line, input bit act, input int row);
    int  bad_pix = -1, bad_rgb = -1, nreq = 0, first_addr = -1;
    bit  seq_ok = 1;
    int  last_addr = -1;
    @(negedge clk);
    ls = 1; ln = 10'(line);
    @(negedge clk);
    ls = 0;
    for (int k = 1; k <= 92; k++) begin
      if (k > 1) @(negedge clk);
      if (rd_en) begin
        if (nreq == 0) first_addr = int'(rd_addr);
        else if (int'(rd_addr) != last_addr + 1) seq_ok = 0;
        last_addr = int'(rd_addr);
        nreq++;
      end
      if (k == 1 && act) chk(rd_en == 1'b1, "R3 request after start", int'(rd_en), 1);
      if (bad_pix < 0 && pix !== (act ? exp_bit(row, k - 3) : 1'b0)) bad_pix = k;
      if (bad_rgb < 0 && rgb !== {3{pix}}) bad_rgb = k;
    end
    if (act) begin
      chk(first_addr == BASE + row*STRIDE, "R5/R6 row address", first_addr, BASE + row*STRIDE);
      chk(nreq == NWORDS && seq_ok, "R7 word count", nreq, NWORDS);
      chk(bad_pix < 0, "R4/R8 pixel stream (bad cycle)", bad_pix, -1);
    end else begin
      chk(nreq == 0, "R9 no read outside window", nreq, 0);
      chk(bad_pix < 0, "R9 pixel low outside window", bad_pix, -1);
    end
    chk(bad_rgb < 0, "R2 rgb follows pixel", bad_rgb, -1);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++)
      mem[a] = 16'(a * 40503 + 16'h3c5a) ^ 16'(a << 7);
    repeat (3) @(negedge clk);
    chk(pix == 0 && rd_en == 0 && rgb == 0, "R1 outputs low in reset", int'({pix, rd_en}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(pix == 0 && rd_en == 0, "R1 outputs low after reset", int'({pix, rd_en}), 0);

    // vector table: line sequence with expected row
    for (int v = 0; v < 14; v++)
      run_line(int'(VEC[v][15:8]), VEC[v][7], int'(VEC[v][6:0]));

    // reset mid-line: pointer back to base, outputs low
    @(negedge clk);
    ls = 1; ln = 10'd6;
    @(negedge clk);
    ls = 0;
    repeat (20) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(pix == 0 && rd_en == 0, "R1 outputs low on mid-line reset", int'({pix, rd_en}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_line(7, 1, 0);   // R1 odd offset after reset reads base row
    run_line(6, 1, 1);   // R5 pointer advanced after odd line
    run_line(4, 1, 1);   // R5 even line keeps pointer
    run_line(5, 1, 1);
    run_line(3, 1, 2);
    finish_run();
  end
endmodule